// File: doc/BRIEF.md
# SDRAM burst column sequencer

This block models the column side of a four-bank SDRAM device. A mode-register-set command takes its configuration from the address pins. The configuration holds the burst length, the burst order, the read latency and the write-burst policy. Read and write commands then step through the column addresses of a burst in the programmed order. Read data leaves the block after the programmed latency. Write data enters one beat per clock and passes through the per-byte masks.

A small storage model sits behind the sequencer so that bursts can be written and read back. It holds four banks of one page each and is cleared by reset. Row activation, refresh and array timing are not modelled. Every command is sampled on the rising clock edge, and a command is only seen while the chip-select input is low.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset the mode is: burst length 1, sequential order, read latency 2, burst writes. The storage reads as zero and `dq_valid` stays low until a read produces data.
- R2: Commands are decoded from {ras_n, cas_n, we_n} only while `cs_n` is low. The codes are: 000 mode set, 101 read, 100 write, 110 burst stop, 010 precharge. Any other code is a no-op. With `cs_n` high, no command changes the mode or the storage.
- R3: A mode set loads four fields from `addr`. Bits 2:0 give the length: 000=1, 001=2, 010=4, 011=8, 111=full page. Bit 3 gives the order: 0 sequential, 1 interleaved. Bits 6:4 give the latency: 010=2, 011=3. Bit 9 gives the write policy: 1 means single-beat writes. A mode set with a reserved length or latency code is ignored as a whole.
- R4: For a read sampled at edge n, beat k of the burst is on `dq_out` with `dq_valid` high during the cycle after edge n+CL+k.
- R5: A read with length 1, 2, 4 or 8 produces exactly that many consecutive beats.
- R6: In sequential order, beat k addresses the column whose low log2(BL) bits are (start+k) mod BL. The upper bits stay those of the start column.
- R7: In interleaved order, beat k addresses the column whose low log2(BL) bits are the start's low bits XOR k. The upper bits stay those of the start column.
- R8: A full-page burst always runs in sequential order and wraps around the page. It continues until a burst stop or precharge command. A beat that falls on the edge of that command is not transferred.
- R9: When single-beat writes are selected, a write stores only the beat sampled with the command. Reads still use the programmed length.
- R10: A write beat sampled with `dm[i]` high leaves byte i (bits 8i+7:8i) of the addressed word unchanged.
- R11: `ba` selects which of the four banks a burst reads or writes. The bank is held for the whole burst.
- R12: A read or write command cancels the burst in progress, and its own burst starts at once. Read beats issued before the new command still appear on `dq_out`.
- R13: A burst write stores the `dq_in` value sampled at edge n+k into the column of beat k, where n is the command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Command bit, row strobe |
| cas_n | input | 1 | Command bit, column strobe |
| we_n | input | 1 | Command bit, write enable |
| ba | input | 2 | Bank select |
| addr | input | ADDR_W | Column address, or mode key during a mode set |
| dq_in | input | DW | Write data |
| dm | input | DW/8 | Per-byte write mask, high blocks the byte |
| dq_out | output | DW | Read data, zero when not valid |
| dq_valid | output | 1 | Read data valid |

## Verification
The bench goes after the wrap points. One read starts in the middle of an aligned block, and a design that carried into the upper column bits would leave the block and return the wrong words. An interleaved read starts at an odd column, where an adder in place of an XOR gives a visibly different order. A full-page read crosses the page end and is then stopped. A design that ended full-page bursts on its own, or let one more beat through after the stop, would differ from the model in the following cycles. The bench also sends reserved mode codes, deselected commands, masked and single-beat writes, and a command that cuts into a running burst. Each of these would show up as stale or extra data when the location is read back.

// File: rtl/sdram_col_seq.sv
`timescale 1ns/1ps
module sdram_col_seq #(
  parameter int DW     = 16,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_in,
  input  logic [DW/8-1:0]   dm,
  output logic [DW-1:0]     dq_out,
  output logic              dq_valid
);
  localparam int NB    = DW / 8;
  localparam int WORDS = 4 << COL_W;

  logic cmd_mrs, cmd_rd, cmd_wr, cmd_stop;
  assign cmd_mrs  = !cs_n && !ras_n && !cas_n && !we_n;
  assign cmd_rd   = !cs_n &&  ras_n && !cas_n &&  we_n;
  assign cmd_wr   = !cs_n &&  ras_n && !cas_n && !we_n;
  assign cmd_stop = !cs_n &&  cas_n && !we_n;

  logic [2:0] bl_code;
  logic       il, cl3, wsingle;
  logic       bl_ok, cl_ok;
  assign bl_ok = (addr[2:0] <= 3'd3) || (addr[2:0] == 3'd7);
  assign cl_ok = (addr[6:4] == 3'd2) || (addr[6:4] == 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_code <= '0;
      il      <= 1'b0;
      cl3     <= 1'b0;
      wsingle <= 1'b0;
    end else if (cmd_mrs && bl_ok && cl_ok) begin
      bl_code <= addr[2:0];
      il      <= addr[3];
      cl3     <= addr[4];
      wsingle <= addr[9];
    end
  end

  logic             full;
  logic [COL_W-1:0] lmask;
  assign full  = (bl_code == 3'd7);
  assign lmask = full ? {COL_W{1'b1}} : COL_W'((1 << bl_code) - 1);

  logic             act, e_wr, e_il, e_full;
  logic [1:0]       e_ba;
  logic [COL_W-1:0] e_start, e_cnt, e_mask, e_col;
  logic             handle, rd_issue;

  assign e_col    = (e_start & ~e_mask) |
                    ((e_il ? (e_start ^ e_cnt) : (e_start + e_cnt)) & e_mask);
  assign handle   = act && !(cmd_rd || cmd_wr || cmd_stop);
  assign rd_issue = handle && !e_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      e_wr    <= 1'b0;
      e_il    <= 1'b0;
      e_full  <= 1'b0;
      e_ba    <= '0;
      e_start <= '0;
      e_cnt   <= '0;
      e_mask  <= '0;
    end else if (cmd_rd || cmd_wr) begin
      act     <= cmd_rd || (!wsingle && (lmask != '0));
      e_wr    <= cmd_wr;
      e_il    <= il && !full;
      e_full  <= full;
      e_ba    <= ba;
      e_start <= addr[COL_W-1:0];
      e_cnt   <= cmd_wr ? COL_W'(1) : '0;
      e_mask  <= lmask;
    end else if (cmd_stop) begin
      act <= 1'b0;
    end else if (act) begin
      e_cnt <= e_cnt + 1'b1;
      if (!e_full && e_cnt == e_mask) act <= 1'b0;
    end
  end

  logic [DW-1:0]      mem [WORDS];
  logic               wr_en;
  logic [COL_W+1:0]   wr_idx;
  assign wr_en  = cmd_wr || (handle && e_wr);
  assign wr_idx = cmd_wr ? {ba, addr[COL_W-1:0]} : {e_ba, e_col};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < NB; b++)
        if (!dm[b]) mem[wr_idx][b*8 +: 8] <= dq_in[b*8 +: 8];
    end
  end

  logic [2:0]    pv;
  logic [DW-1:0] pd [3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int s = 0; s < 3; s++) pd[s] <= '0;
    end else begin
      pv    <= {pv[1:0], rd_issue};
      pd[0] <= mem[{e_ba, e_col}];
      pd[1] <= pd[0];
      pd[2] <= pd[1];
    end
  end

  assign dq_valid = cl3 ? pv[2] : pv[1];
  assign dq_out   = !dq_valid ? '0 : (cl3 ? pd[2] : pd[1]);

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[ADDR_W-1:10], addr[8:7]};
endmodule

module sdram_col_seq_chk #(
  parameter int COL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [2:0]       len_key,
  input logic             dq_valid,
  input logic [2:0]       bl_code,
  input logic             cl3,
  input logic             wsingle,
  input logic             act,
  input logic [COL_W-1:0] e_cnt,
  input logic             rd_issue
);
  logic p_mrs, p_rd, p_wr, p_stop;
  assign p_mrs  = !cs_n && !ras_n && !cas_n && !we_n;
  assign p_rd   = !cs_n &&  ras_n && !cas_n &&  we_n;
  assign p_wr   = !cs_n &&  ras_n && !cas_n && !we_n;
  assign p_stop = !cs_n &&  cas_n && !we_n;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dq_valid);

  a_r2_deselect_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(bl_code) && $stable(cl3) && $stable(wsingle)));

  a_r3_reserved_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (p_mrs && (len_key == 3'd5)) |=> $stable(bl_code));

  a_r4_latency_two: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl3 && dq_valid) |-> $past(rd_issue, 2));

  a_r4_latency_three: assert property (@(posedge clk) disable iff (!rst_n)
    (cl3 && dq_valid) |-> $past(rd_issue, 3));

  a_r8_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    p_stop |=> !act);

  a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (p_wr && wsingle) |=> !act);

  a_r12_read_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    p_rd |=> (act && e_cnt == '0));
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .len_key(addr[2:0]), .dq_valid(dq_valid), .bl_code(bl_code),
  .cl3(cl3), .wsingle(wsingle), .act(act), .e_cnt(e_cnt), .rd_issue(rd_issue)
);

// File: tb/sdram_col_seq_test.sv
`timescale 1ns/1ps
module sdram_col_seq_test;
  localparam int DW = 16, COL_W = 4, ADDR_W = 11, NB = 2, PAGE = 16;
  localparam int HORIZON = 4100, LIMIT = 3000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]        ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0]     dq_in = '0;
  logic [NB-1:0]     dm = '0;
  logic [DW-1:0]     dq_out;
  logic              dq_valid;

  sdram_col_seq #(.DW(DW), .COL_W(COL_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dq_in(dq_in), .dm(dm),
    .dq_out(dq_out), .dq_valid(dq_valid)
  );

  int    checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference model
  int          m_bl, m_cl;
  bit          m_full, m_il, m_ws;
  logic [15:0] mm [4*PAGE];
  bit          ev [HORIZON];
  logic [15:0] ed [HORIZON];
  bit          e_act, e_wr, e_il, e_full;
  int          e_ba, e_st, e_cnt, e_len;

  function automatic int mcol(int st, int k, int len, bit ilv);
    int base = st - (st % len);
    int off  = st % len;
    if (ilv) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  task automatic mwrite(int b, int c);
    for (int i = 0; i < NB; i++)
      if (!dm[i]) mm[b*PAGE + c][i*8 +: 8] = dq_in[i*8 +: 8];
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_bl = 1; m_cl = 2; m_full = 0; m_il = 0; m_ws = 0; e_act = 0;
      for (int i = 0; i < 4*PAGE; i++) mm[i] = '0;
      for (int i = 0; i < HORIZON; i++) ev[i] = 0;
    end else begin
      bit c_mrs, c_rd, c_wr, c_st;
      c_mrs = !cs_n && !ras_n && !cas_n && !we_n;
      c_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;
      c_wr  = !cs_n &&  ras_n && !cas_n && !we_n;
      c_st  = !cs_n &&  cas_n && !we_n;
      if (e_act && !(c_rd || c_wr || c_st)) begin
        int col;
        col = mcol(e_st, e_cnt, e_len, e_il);
        if (e_wr) mwrite(e_ba, col);
        else begin
          ev[cyc + m_cl - 1] = 1;
          ed[cyc + m_cl - 1] = mm[e_ba*PAGE + col];
        end
        e_cnt++;
        if (!e_full && e_cnt == e_len) e_act = 0;
      end
      if (c_mrs) begin
        int code, lat;
        code = int'(addr[2:0]);
        lat  = int'(addr[6:4]);
        if ((code <= 3 || code == 7) && (lat == 2 || lat == 3)) begin
          m_full = (code == 7);
          m_bl   = m_full ? PAGE : (1 << code);
          m_il   = addr[3];
          m_cl   = lat;
          m_ws   = addr[9];
        end
      end else if (c_rd) begin
        e_act = 1; e_wr = 0; e_ba = int'(ba); e_st = int'(addr[3:0]); e_cnt = 0;
        e_len = m_bl; e_full = m_full; e_il = m_full ? 1'b0 : m_il;
      end else if (c_wr) begin
        mwrite(int'(ba), int'(addr[3:0]));
        e_act = !m_ws && (m_bl > 1);
        e_wr = 1; e_ba = int'(ba); e_st = int'(addr[3:0]); e_cnt = 1;
        e_len = m_bl; e_full = m_full; e_il = m_full ? 1'b0 : m_il;
      end else if (c_st) begin
        e_act = 0;
      end
    end
  end

  always @(negedge clk) begin
    logic [15:0] want;
    want = ev[cyc] ? ed[cyc] : 16'h0000;
    checks++;
    if (dq_valid !== ev[cyc] || dq_out !== want) begin
      fails++;
      $display("FAIL %s cycle %0d: dq_valid=%0b dq_out=%h, expected valid=%0b data=%h",
               cur_req, cyc, dq_valid, dq_out, ev[cyc], want);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > LIMIT) begin
    fails++;
    $display("FAIL watchdog (all requirements): cycle %0d, expected below %0d", cyc, LIMIT);
    finish_run();
  end

  task automatic drive(bit c, bit r, bit a, bit w, int b, int ad, logic [15:0] d, logic [1:0] m);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w;
    ba = 2'(b); addr = ADDR_W'(ad); dq_in = d; dm = m;
  endtask

  task automatic nop(int n);
    repeat (n) drive(0, 1, 1, 1, 0, 0, dq_in, 2'b00);
  endtask

  task automatic mrs(int key);
    drive(0, 0, 0, 0, 0, key, 16'h0, 2'b00);
    nop(4);
  endtask

  task automatic rd(int b, int c);
    drive(0, 1, 0, 1, b, c, 16'h0, 2'b00);
  endtask

  task automatic wr(int b, int c, logic [15:0] d0, logic [1:0] m, int beats);
    drive(0, 1, 0, 0, b, c, d0, m);
    for (int k = 1; k < beats; k++) drive(0, 1, 1, 1, 0, 0, d0 + 16'(k * 16'h0111), m);
  endtask

  initial begin
    // R1: reset state and defaults
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    nop(4);
    rd(0, 3); nop(6);
    wr(0, 3, 16'hA1B2, 2'b00, 1); nop(1);
    rd(0, 3); nop(6);

    // R3, R4, R5, R6, R13: BL4 sequential CL3 burst write and read
    cur_req = "R3/R4/R5/R6/R13";
    mrs(11'h032);
    wr(1, 4, 16'h1000, 2'b00, 4); nop(2);
    rd(1, 5); nop(8);

    // R7, R11: BL8 interleaved CL2, two banks
    cur_req = "R7/R11";
    mrs(11'h02B);
    wr(2, 0, 16'h2000, 2'b00, 8); nop(2);
    rd(2, 3); nop(12);
    rd(1, 5); nop(12);

    // R3: reserved length code and reserved latency code are ignored
    cur_req = "R3";
    mrs(11'h034);
    mrs(11'h013);
    rd(2, 1); nop(12);

    // R2: deselected mode set and write have no effect
    cur_req = "R2";
    drive(1, 0, 0, 0, 0, 11'h000, 16'h0, 2'b00);
    drive(1, 1, 0, 0, 2, 1, 16'hFFFF, 2'b00);
    nop(2);
    rd(2, 1); nop(12);

    // R9: single-beat writes, reads still burst
    cur_req = "R9";
    mrs(11'h222);
    wr(3, 9, 16'h3000, 2'b00, 4); nop(2);
    rd(3, 8); nop(8);

    // R10: byte masks
    cur_req = "R10";
    wr(3, 10, 16'h5566, 2'b01, 1);
    wr(3, 11, 16'h7788, 2'b10, 1); nop(2);
    rd(3, 8); nop(8);

    // R8: full page wraps until stop or precharge
    cur_req = "R8";
    mrs(11'h027);
    rd(2, 14); nop(20);
    drive(0, 1, 1, 0, 0, 0, 16'h0, 2'b00); nop(8);
    rd(0, 0); nop(5);
    drive(0, 0, 1, 0, 0, 0, 16'h0, 2'b00); nop(8);
    wr(0, 8, 16'h4000, 2'b00, 5);
    drive(0, 1, 1, 0, 0, 0, 16'h0, 2'b00); nop(2);
    rd(0, 6); nop(10);
    drive(0, 1, 1, 0, 0, 0, 16'h0, 2'b00); nop(8);

    // R12: new commands cut into running bursts
    cur_req = "R12";
    mrs(11'h033);
    rd(1, 0); nop(2);
    rd(2, 4); nop(12);
    rd(0, 8); nop(3);
    wr(0, 9, 16'h6000, 2'b11, 1); nop(12);
    rd(0, 8); nop(14);

    finish_run();
  end
endmodule